// File: doc/BRIEF.md
# Flash Read Dummy and Mode Phase Sequencer

This block times the gap between the address phase and the read-data phase of a memory-mapped serial flash read. A controller pulses `start_i` once the last address bit has left. The block then counts a programmed number of dummy bytes in shift-clock ticks. During the first ticks of that gap it drives an 8-bit mode value on the same lanes that carried the address. After the mode value it holds the pins at their last driven value. A 2-bit code chooses when output enable drops: at once, after half the mode value, after the whole mode value, or never.

The lane width is latched at start. One byte of the gap lasts 8, 4 or 2 ticks for 1, 2 or 4 lanes. At the end the block pulses `done_o` and releases every lane, so the controller can begin sampling read data. The opcode, address and data phases, clock generation and chip select are handled elsewhere.

Top module: `dmy_phase_seq`

## Requirements
- R1: `width_i` is latched at start and selects the lanes: 0 selects one lane (lane 0), 1 selects two lanes (lanes 1:0), 2 selects four lanes (lanes 3:0), and the reserved code 3 behaves as one lane. Lanes outside the selection always have `dq_o` and `dq_oe_o` low.
- R2: The gap lasts `dummy_bytes_i` x 8 / lanes ticks. `done_o` is high in the cycle after the clock edge that samples the last tick of the gap. When the count is 0, the first tick after start ends the gap.
- R3: While the mode value is being sent, tick k of the gap (counting from 0) drives bit group k of the mode value, most significant group first. Within a group, the highest selected lane carries the most significant bit.
- R4: Once all 8 mode bits have been sent, `dq_o` holds the last group until the gap ends. It also stays stable between ticks.
- R5: Tristate code 0 keeps `dq_oe_o` low for the whole gap.
- R6: Tristate code 1 keeps the selected lanes enabled for the first 4/lanes ticks. Code 2 keeps them enabled for the first 8/lanes ticks. Neither code extends enable past the end of the gap, and enable never comes back on within a gap.
- R7: Tristate code 3 keeps the selected lanes enabled for every tick of a nonzero gap.
- R8: `done_o` is a single-cycle pulse. In that cycle, and whenever the block is idle, `dq_oe_o` is all zero.
- R9: `start_i` has no effect while a gap is running. `tick_i` has no effect while the block is idle.
- R10: After reset, `dq_o`, `dq_oe_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a gap (used only when idle) |
| width_i | input | 2 | Address lane width code |
| dummy_bytes_i | input | CNT_W | Dummy byte count |
| mode_i | input | MODE_W | Mode value |
| tri_code_i | input | 2 | Tristate timing code |
| tick_i | input | 1 | Shift-clock tick |
| dq_o | output | 4 | Per-lane output data |
| dq_oe_o | output | 4 | Per-lane output enable |
| done_o | output | 1 | Gap complete pulse |

## Verification
The assertions check on every cycle the following properties:
- enables and data stay inside the latched lane mask;
- `done_o` only follows a tick while active, is a single-cycle pulse, and comes with released outputs;
- enable never re-asserts once it has dropped in a gap;
- data holds once the mode value is exhausted;
- a start during a gap leaves the latched length untouched.

Only the bench scenarios can show the following, comparing them against reference functions for every tick:
- the exact tick on which enable drops for each code and width;
- the bit order of the mode groups;
- the total gap length for each byte count, including the zero-byte case.

// File: rtl/dmy_seq_pkg.sv
package dmy_seq_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    W_X1  = 2'd0,
    W_X2  = 2'd1,
    W_X4  = 2'd2,
    W_RSV = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    TRI_NOW    = 2'd0,
    TRI_HALF   = 2'd1,
    TRI_FULL   = 2'd2,
    TRI_NEVER  = 2'd3
  } tri_code_e;
endpackage

// File: rtl/dmy_cfg_dec.sv
module dmy_cfg_dec
  import dmy_seq_pkg::*;
#(
  parameter int unsigned MODE_W = 8,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned TICK_W = 7
) (
  input  logic [1:0]        width_i,
  input  logic [CNT_W-1:0]  bytes_i,
  input  logic [1:0]        tri_i,
  output logic [1:0]        lg_o,
  output logic [LANES-1:0]  mask_o,
  output logic [TICK_W-1:0] total_o,
  output logic [TICK_W-1:0] groups_o,
  output logic [TICK_W-1:0] thr_o,
  output logic              never_o
);
  localparam int unsigned BYTE_SH = $clog2(MODE_W);

  always_comb begin
    case (width_e'(width_i))
      W_X2:    begin lg_o = 2'd1; mask_o = LANES'(4'b0011); end
      W_X4:    begin lg_o = 2'd2; mask_o = LANES'(4'b1111); end
      default: begin lg_o = 2'd0; mask_o = LANES'(4'b0001); end
    endcase
    total_o  = TICK_W'(bytes_i) << (BYTE_SH - 32'(lg_o));
    groups_o = TICK_W'(MODE_W) >> lg_o;
    never_o  = 1'b0;
    case (tri_code_e'(tri_i))
      TRI_NOW:   thr_o = '0;
      TRI_HALF:  thr_o = TICK_W'(MODE_W / 2) >> lg_o;
      TRI_FULL:  thr_o = TICK_W'(MODE_W) >> lg_o;
      default: begin
        thr_o   = '0;
        never_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dmy_tick_ctr.sv
module dmy_tick_ctr #(
  parameter int unsigned TICK_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [TICK_W-1:0] total_i,
  output logic              active_o,
  output logic [TICK_W-1:0] cnt_o,
  output logic              done_o
);
  logic [TICK_W:0] cnt_nxt;
  assign cnt_nxt = {1'b0, cnt_o} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        active_o <= 1'b1;
        cnt_o    <= '0;
      end else if (adv_i && active_o) begin
        // zero-length gap also ends here on the first tick
        if (cnt_nxt >= {1'b0, total_i}) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          cnt_o <= cnt_nxt[TICK_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/dmy_mode_shift.sv
module dmy_mode_shift
  import dmy_seq_pkg::*;
#(
  parameter int unsigned MODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              shift_i,
  input  logic [1:0]        lg_i,
  output logic [LANES-1:0]  group_o
);
  logic [MODE_W-1:0] sr_q;
  int unsigned nl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= mode_i;
    end else if (shift_i) begin
      case (lg_i)
        2'd0:    sr_q <= sr_q << 1;
        2'd1:    sr_q <= sr_q << 2;
        default: sr_q <= sr_q << 4;
      endcase
    end
  end

  // top lanes-wide slice, highest lane gets the MSB
  always_comb begin
    nl      = 32'd1 << lg_i;
    group_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (l < nl) group_o[l] = sr_q[MODE_W - nl + l];
    end
  end
endmodule

// File: rtl/dmy_phase_seq.sv
module dmy_phase_seq
  import dmy_seq_pkg::*;
#(
  parameter int unsigned MODE_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        width_i,
  input  logic [CNT_W-1:0]  dummy_bytes_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        tri_code_i,
  input  logic              tick_i,
  output logic [LANES-1:0]  dq_o,
  output logic [LANES-1:0]  dq_oe_o,
  output logic              done_o
);
  localparam int unsigned TICK_W = CNT_W + $clog2(MODE_W) + 1;

  logic [1:0]        lg_d, lg_q;
  logic [LANES-1:0]  mask_d, mask_q;
  logic [TICK_W-1:0] total_d, total_q;
  logic [TICK_W-1:0] groups_d, groups_q;
  logic [TICK_W-1:0] thr_d, thr_q;
  logic              never_d, never_q;
  logic              active_q, load, shift, oe_on;
  logic [TICK_W-1:0] cnt_q;
  logic [LANES-1:0]  group;

  dmy_cfg_dec #(.MODE_W(MODE_W), .CNT_W(CNT_W), .TICK_W(TICK_W)) u_dec (
    .width_i (width_i),
    .bytes_i (dummy_bytes_i),
    .tri_i   (tri_code_i),
    .lg_o    (lg_d),
    .mask_o  (mask_d),
    .total_o (total_d),
    .groups_o(groups_d),
    .thr_o   (thr_d),
    .never_o (never_d)
  );

  assign load = start_i && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lg_q     <= '0;
      mask_q   <= '0;
      total_q  <= '0;
      groups_q <= '0;
      thr_q    <= '0;
      never_q  <= 1'b0;
    end else if (load) begin
      lg_q     <= lg_d;
      mask_q   <= mask_d;
      total_q  <= total_d;
      groups_q <= groups_d;
      thr_q    <= thr_d;
      never_q  <= never_d;
    end
  end

  dmy_tick_ctr #(.TICK_W(TICK_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .adv_i   (tick_i),
    .total_i (total_q),
    .active_o(active_q),
    .cnt_o   (cnt_q),
    .done_o  (done_o)
  );

  // stop shifting on the last mode group so the pins hold it
  assign shift = tick_i && active_q && ((cnt_q + 1'b1) < groups_q);

  dmy_mode_shift #(.MODE_W(MODE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .mode_i (mode_i),
    .shift_i(shift),
    .lg_i   (lg_q),
    .group_o(group)
  );

  assign oe_on   = active_q && (cnt_q < total_q) && (never_q || (cnt_q < thr_q));
  assign dq_oe_o = oe_on ? mask_q : '0;
  assign dq_o    = active_q ? (group & mask_q) : '0;
endmodule

// File: rtl/dmy_phase_seq_chk.sv
module dmy_phase_seq_chk #(
  parameter int unsigned TICK_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              tick_i,
  input logic [3:0]        dq_o,
  input logic [3:0]        dq_oe_o,
  input logic              done_o,
  input logic              active_q,
  input logic [TICK_W-1:0] cnt_q,
  input logic [TICK_W-1:0] groups_q,
  input logic [TICK_W-1:0] total_q,
  input logic [3:0]        mask_q
);
  assert_lane_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dq_oe_o & ~mask_q) == 4'd0) && ((dq_o & ~mask_q) == 4'd0));

  assert_done_after_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tick_i) && $past(active_q));

  assert_hold_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && (($past(cnt_q) + 1'b1) >= groups_q)) |-> $stable(dq_o));

  assert_no_reenable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && ($past(dq_oe_o) == 4'd0)) |-> (dq_oe_o == 4'd0));

  assert_done_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dq_oe_o == 4'd0) && !active_q);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && start_i && !tick_i) |=> active_q && $stable(total_q));

  assert_idle_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && tick_i) |=> !done_o);
endmodule

bind dmy_phase_seq dmy_phase_seq_chk #(.TICK_W(TICK_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .tick_i  (tick_i),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o),
  .done_o  (done_o),
  .active_q(active_q),
  .cnt_q   (cnt_q),
  .groups_q(groups_q),
  .total_q (total_q),
  .mask_q  (mask_q)
);

// File: tb/sim_dmy_phase_seq.sv
module sim_dmy_phase_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] width_i = '0;
  logic [2:0] dummy_bytes_i = '0;
  logic [7:0] mode_i = '0;
  logic [1:0] tri_code_i = '0;
  logic       tick_i = 1'b0;
  logic [3:0] dq_o, dq_oe_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dmy_phase_seq u0 (.*);

  function automatic int lanes_of(input logic [1:0] w);
    return (w == 2'd1) ? 2 : (w == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic [3:0] exp_oe(input int k, input int total, input logic [1:0] code,
                                        input int nl);
    int thr;
    thr = (code == 2'd1) ? 4 / nl : (code == 2'd2) ? 8 / nl : 0;
    if (k < total && (code == 2'd3 || k < thr)) return 4'((1 << nl) - 1);
    return 4'd0;
  endfunction

  function automatic logic [3:0] exp_dq(input int k, input logic [7:0] m, input int nl);
    int g;
    logic [3:0] r;
    g = (k < 8 / nl) ? k : 8 / nl - 1;
    r = '0;
    for (int l = 0; l < nl; l++) r[l] = m[8 - nl + l - g * nl];
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_tick(input int k, input int total, input logic [1:0] code,
                            input logic [7:0] m, input int nl);
    logic [3:0] eo;
    logic [3:0] msk;
    string tg;
    msk = 4'((1 << nl) - 1);
    eo  = exp_oe(k, total, code, nl);
    tg  = (code == 2'd0) ? "R5" : (code == 2'd3) ? "R7" : "R6";
    check(dq_oe_o == eo, tg, dq_oe_o, eo);
    check((dq_o & ~msk) == 4'd0, "R1 unused lanes", dq_o, 0);
    check(done_o == 1'b0, "R2 early done", done_o, 0);
    if (eo != 4'd0)
      check(dq_o == exp_dq(k, m, nl), (k < 8 / nl) ? "R3 mode group" : "R4 hold",
            dq_o, exp_dq(k, m, nl));
  endtask

  task automatic run_case(input logic [1:0] w, input logic [2:0] nb, input logic [1:0] code,
                          input logic [7:0] m, input bit busy_start);
    int nl, total, iters;
    nl    = lanes_of(w);
    total = int'(nb) * 8 / nl;
    iters = (total == 0) ? 1 : total;
    @(negedge clk_i);
    width_i = w; dummy_bytes_i = nb; tri_code_i = code; mode_i = m; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < iters; k++) begin
      check_tick(k, total, code, m, nl);
      if (busy_start && k == 0) begin
        width_i = ~w; dummy_bytes_i = ~nb; tri_code_i = ~code; mode_i = ~m; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        check_tick(k, total, code, m, nl);  // R9 start ignored
      end
      for (int g = 0; g < int'($urandom % 3); g++) begin
        @(negedge clk_i);
        check_tick(k, total, code, m, nl);  // R4 stable between ticks
      end
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
    check(done_o == 1'b1, "R2 done timing", done_o, 1);
    check(dq_oe_o == 4'd0, "R8 release at done", dq_oe_o, 0);
    @(negedge clk_i);
    check(done_o == 1'b0, "R8 single pulse", done_o, 0);
    check(dq_oe_o == 4'd0, "R8 idle release", dq_oe_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    check(dq_o == 4'd0 && dq_oe_o == 4'd0 && done_o == 1'b0, "R10 reset", {dq_o, dq_oe_o}, 0);
    rst_ni = 1'b1;
    // R9 ticks while idle
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
      check(done_o == 1'b0 && dq_oe_o == 4'd0, "R9 idle tick", done_o, 0);
    end
    run_case(2'd0, 3'd1, 2'd0, 8'hA5, 1'b0);  // R5
    run_case(2'd0, 3'd2, 2'd1, 8'hC3, 1'b0);  // R6
    run_case(2'd1, 3'd2, 2'd1, 8'h96, 1'b0);  // R6
    run_case(2'd2, 3'd3, 2'd1, 8'h5A, 1'b0);  // R6
    run_case(2'd2, 3'd1, 2'd2, 8'hE7, 1'b0);  // R6 threshold equals gap
    run_case(2'd0, 3'd1, 2'd2, 8'h81, 1'b0);  // R6
    run_case(2'd2, 3'd7, 2'd3, 8'h3C, 1'b0);  // R7
    run_case(2'd1, 3'd4, 2'd3, 8'hB4, 1'b0);  // R4 long hold
    run_case(2'd3, 3'd1, 2'd3, 8'h69, 1'b0);  // R1 reserved width
    run_case(2'd1, 3'd0, 2'd3, 8'hFF, 1'b0);  // R2 zero bytes
    run_case(2'd2, 3'd2, 2'd3, 8'h12, 1'b1);  // R9 start while busy
    for (int i = 0; i < 40; i++)
      run_case(2'($urandom), 3'($urandom), 2'($urandom), 8'($urandom), 1'($urandom));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule